// File: doc/BRIEF.md
# UART Register Front End with Staged Baud Divisor

This block sits between a simple word-addressed register bus and the serial side of a UART. It owns a transmit FIFO and a receive FIFO. Software writes characters into the transmit FIFO through the data register and takes received characters out through the same register. Each received character carries a 4-bit error tag, and the tag comes back with the character. The serial shifter is not part of this block. It drains the transmit FIFO through a pop strobe and fills the receive FIFO through a push strobe, handing over a character and its error tag.

The baud divisor has an integer part and a 6-bit fractional part (1/64 steps). Both parts are written into shadow storage. They reach the tick generator only when the line control register is written. The tick generator gives one pulse per period of (integer + fractional/64) clocks, which is the 16x oversampling rate. It carries the fractional remainder from one period to the next, so the average period is exact. Ten interrupt sources are latched into a raw status register, cleared by writing ones, and gated by a mask into a single interrupt line.

Bus register offsets, in word units on `bus_addr`: 0 data, 1 receive error status, 2 flags, 3 integer divisor, 4 fractional divisor, 5 line control, 6 interrupt mask, 7 raw interrupt status, 8 masked interrupt status, 9 interrupt clear. A read returns its value on `bus_rdata` one clock after the cycle that has `bus_rd` high.

Top module: `uart_regif`

## Requirements
- R1: A write to offset 0 pushes `bus_wdata[7:0]` into the transmit FIFO, and `tx_head` presents the characters in write order. A write while the FIFO is full is dropped, and the stored characters stay intact.
- R2: A read of offset 0 returns the oldest received character in bits [7:0] and its error tag in bits [11:8], with zero above, and removes that character. A read while the receive FIFO is empty returns 0 and leaves the FIFO unchanged.
- R3: A read of offset 2 returns the flags: bit 7 transmit empty, bit 6 receive full, bit 5 transmit full, bit 4 receive empty, bit 3 busy, bit 2 `modem_dcd`, bit 1 `modem_dsr`, bit 0 `modem_cts`.
- R4: The busy flag is 1 whenever the transmit FIFO holds a character or `tx_active` is high, and 0 otherwise.
- R5: The error tag encoding is framing at bit 0, parity at bit 1, break at bit 2 and overrun at bit 3. Offset 1 returns the tag of the last character read from offset 0, and any write to offset 1 clears it to 0.
- R6: Writes to offsets 3 and 4 go into shadow registers. `div_int_act` and `div_frac_act` pick up the shadow values only on a write to offset 5, even if the value written there is unchanged. Offset 5 also drives `line_ctl`.
- R7: After an offset-5 write, `tick16` pulses exactly floor(64·K / (64·int + frac)) times in the following K clocks. When the active integer divisor is 0, `tick16` stays low.
- R8: Offset 6 holds a 10-bit interrupt mask taken from `bus_wdata[9:0]`. Higher bits are ignored and read back as 0.
- R9: The raw status at offset 7 latches these events:
  - bit 0: a received character is accepted;
  - bit 1: a transmit pop leaves the FIFO empty;
  - bits 2, 3 and 4: an accepted character carries framing, parity or break;
  - bit 5: a character carries overrun or arrives at a full receive FIFO;
  - bit 6: a transmit write is dropped;
  - bits 7, 8 and 9: `modem_cts`, `modem_dcd` or `modem_dsr` changes.

  Writing ones to offset 9 clears those bits. An event in the same cycle as a clear wins.
- R10: `irq` is the OR of raw status AND mask, and offset 8 returns raw status AND mask.
- R11: A receive push while the receive FIFO is full is dropped, and the characters already stored stay intact.
- R12: After reset, both FIFOs are empty, and the status, mask, raw status, line control and both divisors (shadow and active) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (offset 0 read pops) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the clock after `bus_rd` |
| tx_head | output | 8 | Oldest character in the transmit FIFO |
| tx_pop | input | 1 | Shifter takes the head character |
| tx_active | input | 1 | Shifter is sending a character |
| rx_push | input | 1 | Shifter delivers a character |
| rx_char | input | 8 | Delivered character |
| rx_err | input | 4 | Error tag of the delivered character |
| modem_cts | input | 1 | Clear-to-send input |
| modem_dsr | input | 1 | Data-set-ready input |
| modem_dcd | input | 1 | Carrier-detect input |
| line_ctl | output | 8 | Line control register value |
| div_int_act | output | 16 | Active integer divisor |
| div_frac_act | output | 6 | Active fractional divisor |
| tick16 | output | 1 | 16x oversampling tick |
| irq | output | 1 | Masked interrupt |

## Verification
Corruption of a FIFO pointer or count shows up quickly. Characters come back in the wrong order or with the wrong error tag, or the full and empty flags stop matching the number of characters pushed and popped. This is visible on the next data read or flag read. A divisor that goes live without an offset-5 write shows on `div_int_act` in the next clock and on the tick count over the next window. A fraction that is dropped or not carried between periods gives a tick total that is off by one or more within a few hundred clocks. A raw status bit that is latched wrongly or left uncleared appears on `irq` in the same cycle as the mask write that selects it.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  localparam int CHAR_W = 8;
  localparam int ERR_W  = 4;
  localparam int FRAC_W = 6;
  localparam int IRQ_N  = 10;
  localparam int BUS_W  = 16;

  localparam logic [3:0] OFS_DATA  = 4'd0;
  localparam logic [3:0] OFS_ESTAT = 4'd1;
  localparam logic [3:0] OFS_FLAGS = 4'd2;
  localparam logic [3:0] OFS_DIVI  = 4'd3;
  localparam logic [3:0] OFS_DIVF  = 4'd4;
  localparam logic [3:0] OFS_LCTL  = 4'd5;
  localparam logic [3:0] OFS_MASK  = 4'd6;
  localparam logic [3:0] OFS_RAW   = 4'd7;
  localparam logic [3:0] OFS_MSKD  = 4'd8;
  localparam logic [3:0] OFS_ICLR  = 4'd9;

  // interrupt event positions
  localparam int EV_RXGOT = 0;
  localparam int EV_TXDRN = 1;
  localparam int EV_FRM   = 2;
  localparam int EV_PAR   = 3;
  localparam int EV_BRK   = 4;
  localparam int EV_OVR   = 5;
  localparam int EV_TXDRP = 6;
  localparam int EV_CTS   = 7;
  localparam int EV_DCD   = 8;
  localparam int EV_DSR   = 9;

  function automatic logic [7:0] pack_flags(
    input logic tx_empty, input logic rx_full, input logic tx_full,
    input logic rx_empty, input logic busy, input logic dcd,
    input logic dsr, input logic cts);
    return {tx_empty, rx_full, tx_full, rx_empty, busy, dcd, dsr, cts};
  endfunction
endpackage

// File: rtl/uart_regif_fifo.sv
module uart_regif_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic                           pop,
  input  logic [W-1:0]                   wdata,
  output logic [W-1:0]                   head,
  output logic                           empty,
  output logic                           full,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rp];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt) && $stable(wp)); // R1

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (cnt == '0) && $stable(rp)); // R2
endmodule

// File: rtl/uart_regif_baud.sv
module uart_regif_baud #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIV_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int DW = DIV_W + FRAC_W;
  localparam int AW = DW + 1;
  localparam logic [AW-1:0] STEP = AW'(1) << FRAC_W;

  logic [AW-1:0] acc;
  logic [AW-1:0] acc_nx;
  logic          hit;

  // one clock of progress: add a whole clock in 1/64 units, wrap by divisor
  function automatic logic [AW:0] advance(input logic [AW-1:0] a,
                                          input logic [DW-1:0] d);
    logic [AW-1:0] s;
    s = a + STEP;
    if (s >= {1'b0, d}) return {1'b1, s - {1'b0, d}};
    return {1'b0, s};
  endfunction

  always_comb begin
    {hit, acc_nx} = advance(acc, {div_int, div_frac});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else if (load || div_int == '0) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= acc_nx;
      tick <= hit;
    end
  end

  AST_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (div_int == '0) |=> !tick); // R7
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  input  logic         mask_we,
  input  logic [N-1:0] mask_bits,
  output logic [N-1:0] ris,
  output logic [N-1:0] imsc,
  output logic         irq
);
  logic [N-1:0] keep;

  assign keep = clr_we ? ~clr_bits : '1;
  assign irq  = |(ris & imsc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ris  <= '0;
      imsc <= '0;
    end else begin
      ris <= (ris & keep) | ev;
      if (mask_we) imsc <= mask_bits;
    end
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ev == '0) |=> ((ris & $past(clr_bits)) == '0)); // R9
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0]           bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [CHAR_W-1:0]    tx_head,
  input  logic                 tx_pop,
  input  logic                 tx_active,
  input  logic                 rx_push,
  input  logic [CHAR_W-1:0]    rx_char,
  input  logic [ERR_W-1:0]     rx_err,
  input  logic                 modem_cts,
  input  logic                 modem_dsr,
  input  logic                 modem_dcd,
  output logic [7:0]           line_ctl,
  output logic [DIV_W-1:0]     div_int_act,
  output logic [FRAC_W-1:0]    div_frac_act,
  output logic                 tick16,
  output logic                 irq
);
  localparam int CW   = $clog2(FIFO_DEPTH+1);
  localparam int RX_W = CHAR_W + ERR_W;

  // decoded bus strobes
  logic wr_data, rd_data, wr_estat, wr_divi, wr_divf, wr_lctl, wr_mask, wr_iclr;
  assign wr_data  = bus_wr && bus_addr == OFS_DATA;
  assign rd_data  = bus_rd && bus_addr == OFS_DATA;
  assign wr_estat = bus_wr && bus_addr == OFS_ESTAT;
  assign wr_divi  = bus_wr && bus_addr == OFS_DIVI;
  assign wr_divf  = bus_wr && bus_addr == OFS_DIVF;
  assign wr_lctl  = bus_wr && bus_addr == OFS_LCTL;
  assign wr_mask  = bus_wr && bus_addr == OFS_MASK;
  assign wr_iclr  = bus_wr && bus_addr == OFS_ICLR;

  // transmit FIFO
  logic          tx_empty, tx_full;
  logic [CW-1:0] tx_cnt;
  uart_regif_fifo #(.W(CHAR_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(wr_data), .pop(tx_pop),
    .wdata(bus_wdata[CHAR_W-1:0]), .head(tx_head),
    .empty(tx_empty), .full(tx_full), .count(tx_cnt));

  // receive FIFO, entry = {error tag, character}
  logic            rx_empty, rx_full;
  logic [CW-1:0]   rx_cnt;
  logic [RX_W-1:0] rx_head;
  logic            rx_pop;
  assign rx_pop = rd_data && !rx_empty;
  uart_regif_fifo #(.W(RX_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rx_pop),
    .wdata({rx_err, rx_char}), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt));

  // named events
  logic tx_accept, rx_accept, tx_drop, tx_drained, busy;
  assign tx_accept  = wr_data && !tx_full;
  assign rx_accept  = rx_push && !rx_full;
  assign tx_drop    = wr_data && tx_full;
  assign tx_drained = tx_pop && tx_cnt == CW'(1) && !tx_accept;
  assign busy       = !tx_empty || tx_active;

  logic cts_q, dsr_q, dcd_q;
  logic [IRQ_N-1:0] ev;
  always_comb begin
    ev            = '0;
    ev[EV_RXGOT]  = rx_accept;
    ev[EV_TXDRN]  = tx_drained;
    ev[EV_FRM]    = rx_accept && rx_err[0];
    ev[EV_PAR]    = rx_accept && rx_err[1];
    ev[EV_BRK]    = rx_accept && rx_err[2];
    ev[EV_OVR]    = rx_push && (rx_err[3] || rx_full);
    ev[EV_TXDRP]  = tx_drop;
    ev[EV_CTS]    = modem_cts ^ cts_q;
    ev[EV_DCD]    = modem_dcd ^ dcd_q;
    ev[EV_DSR]    = modem_dsr ^ dsr_q;
  end

  logic [IRQ_N-1:0] ris, imsc;
  uart_regif_irq #(.N(IRQ_N)) irq_i (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .clr_we(wr_iclr), .clr_bits(bus_wdata[IRQ_N-1:0]),
    .mask_we(wr_mask), .mask_bits(bus_wdata[IRQ_N-1:0]),
    .ris(ris), .imsc(imsc), .irq(irq));

  // divisor shadow and active copies, line control, error status
  logic [DIV_W-1:0]  divi_sh;
  logic [FRAC_W-1:0] divf_sh;
  logic [ERR_W-1:0]  estat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divi_sh      <= '0;
      divf_sh      <= '0;
      div_int_act  <= '0;
      div_frac_act <= '0;
      line_ctl     <= '0;
      estat        <= '0;
      cts_q        <= 1'b0;
      dsr_q        <= 1'b0;
      dcd_q        <= 1'b0;
    end else begin
      cts_q <= modem_cts;
      dsr_q <= modem_dsr;
      dcd_q <= modem_dcd;
      if (wr_divi) divi_sh <= bus_wdata[DIV_W-1:0];
      if (wr_divf) divf_sh <= bus_wdata[FRAC_W-1:0];
      if (wr_lctl) begin
        line_ctl     <= bus_wdata[7:0];
        div_int_act  <= divi_sh;
        div_frac_act <= divf_sh;
      end
      if (wr_estat)    estat <= '0;
      else if (rx_pop) estat <= rx_head[RX_W-1:CHAR_W];
    end
  end

  uart_regif_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .load(wr_lctl),
    .div_int(div_int_act), .div_frac(div_frac_act), .tick(tick16));

  // read mux and registered read data
  logic [BUS_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_DATA:  rd_mux = rx_empty ? '0 : BUS_W'(rx_head);
      OFS_ESTAT: rd_mux = BUS_W'(estat);
      OFS_FLAGS: rd_mux = BUS_W'(pack_flags(tx_empty, rx_full, tx_full, rx_empty,
                                             busy, modem_dcd, modem_dsr, modem_cts));
      OFS_DIVI:  rd_mux = BUS_W'(divi_sh);
      OFS_DIVF:  rd_mux = BUS_W'(divf_sh);
      OFS_LCTL:  rd_mux = BUS_W'(line_ctl);
      OFS_MASK:  rd_mux = BUS_W'(imsc);
      OFS_RAW:   rd_mux = BUS_W'(ris);
      OFS_MSKD:  rd_mux = BUS_W'(ris & imsc);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_DIV_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lctl |=> $stable(div_int_act) && $stable(div_frac_act)); // R6

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_empty) |=> (bus_rdata == '0) && $stable(rx_cnt)); // R2

  AST_BUSY_WHILE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tx_full) |=> !tx_empty); // R4
endmodule

// File: tb/uart_regif_tb_top.sv
module uart_regif_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  tx_head;
  logic        tx_pop = 1'b0, tx_active = 1'b0, rx_push = 1'b0;
  logic [7:0]  rx_char = '0;
  logic [3:0]  rx_err = '0;
  logic        modem_cts = 1'b0, modem_dsr = 1'b0, modem_dcd = 1'b0;
  logic [7:0]  line_ctl;
  logic [15:0] div_int_act;
  logic [5:0]  div_frac_act;
  logic        tick16, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regif #(.FIFO_DEPTH(DEPTH), .DIV_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_head(tx_head), .tx_pop(tx_pop),
    .tx_active(tx_active), .rx_push(rx_push), .rx_char(rx_char), .rx_err(rx_err),
    .modem_cts(modem_cts), .modem_dsr(modem_dsr), .modem_dcd(modem_dcd),
    .line_ctl(line_ctl), .div_int_act(div_int_act), .div_frac_act(div_frac_act),
    .tick16(tick16), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk); bus_addr = a; bus_wdata = 16'(d); bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = int'(bus_rdata);
  endtask

  task automatic rx_send(input int ch, input int er);
    @(negedge clk); rx_char = 8'(ch); rx_err = 4'(er); rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic tx_take(output int ch);
    @(negedge clk); ch = int'(tx_head); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic count_ticks(input int k, output int n);
    n = 0;
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      if (tick16) n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v, n, ris_exp;
    int fr[4] = '{0, 1, 33, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'd2, v);  chk("R12 flags after reset", v, 'h90);
    rd(4'd1, v);  chk("R12 error status after reset", v, 0);
    rd(4'd6, v);  chk("R12 mask after reset", v, 0);
    rd(4'd7, v);  chk("R12 raw status after reset", v, 0);
    chk("R12 line control after reset", int'(line_ctl), 0);
    chk("R12 active divisor after reset", int'(div_int_act), 0);
    count_ticks(100, n); chk("R7 no ticks with zero divisor", n, 0);

    // transmit FIFO: fill, overfill, drain
    wr(4'd9, 'h3FF);
    for (int i = 0; i <= DEPTH; i++) wr(4'd0, 'hA0 + i);
    rd(4'd2, v);  chk("R3 flags transmit full", v, 'h38);
    rd(4'd7, v);  chk("R9 dropped write event", v, 'h040);
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(v); chk("R1 transmit order", v, 'hA0 + i);
    end
    rd(4'd2, v);  chk("R3 flags transmit drained", v, 'h90);
    rd(4'd7, v);  chk("R9 drain event", v, 'h042);

    // busy
    wr(4'd0, 'h55);
    rd(4'd2, v);  chk("R4 busy with queued character", v, 'h18);
    tx_take(v);   chk("R1 single character", v, 'h55);
    tx_active = 1'b1;
    rd(4'd2, v);  chk("R4 busy with shifter active", v, 'h98);
    tx_active = 1'b0;
    rd(4'd2, v);  chk("R4 idle", v, 'h90);

    // error tag sweep over all 16 codes
    for (int e = 0; e < 16; e++) begin
      wr(4'd9, 'h3FF);
      rx_send(e * 7 + 3, e);
      rd(4'd7, v);  chk("R9 receive events per tag", v, 1 | (e << 2));
      rd(4'd0, v);  chk("R2 data with tag", v, (e << 8) | (e * 7 + 3));
      rd(4'd1, v);  chk("R5 error status", v, e);
    end
    wr(4'd1, 0);
    rd(4'd1, v);  chk("R5 status cleared by write", v, 0);

    // receive FIFO overfill and empty read
    wr(4'd9, 'h3FF);
    for (int i = 0; i <= DEPTH; i++) rx_send('h30 + i, 0);
    rd(4'd2, v);  chk("R3 flags receive full", v, 'hC0);
    rd(4'd7, v);  chk("R11 overflow event", v, 'h021);
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'd0, v); chk("R11 stored characters intact", v, 'h30 + i);
    end
    rd(4'd0, v);  chk("R2 empty read returns zero", v, 0);
    rd(4'd0, v);  chk("R2 second empty read", v, 0);
    rx_send('h7E, 2);
    rd(4'd0, v);  chk("R2 pointers unchanged by empty read", v, 'h27E);
    rd(4'd0, v);  chk("R2 empty again", v, 0);

    // divisor staging and tick sweep
    for (int i = 1; i <= 4; i++) begin
      for (int f = 0; f < 4; f++) begin
        wr(4'd3, i);
        wr(4'd4, fr[f]);
        if (i == 4 && f == 0) begin
          rd(4'd3, v); chk("R6 shadow readback", v, 4);
          chk("R6 active unchanged before line write", int'(div_int_act), 3);
          chk("R6 active fraction unchanged", int'(div_frac_act), 63);
        end
        wr(4'd5, 'h70);
        chk("R6 active integer after line write", int'(div_int_act), i);
        chk("R6 active fraction after line write", int'(div_frac_act), fr[f]);
        count_ticks(400, n);
        chk("R7 tick count", n, (64 * 400) / (i * 64 + fr[f]));
      end
    end
    chk("R6 line control output", int'(line_ctl), 'h70);
    wr(4'd3, 2);
    chk("R6 still staged", int'(div_int_act), 4);
    wr(4'd5, 'h70);
    chk("R6 same-value line write applies", int'(div_int_act), 2);
    wr(4'd3, 0); wr(4'd5, 'h70);
    count_ticks(100, n); chk("R7 zero divisor stops ticks", n, 0);

    // mask width and masked interrupt sweep
    wr(4'd6, 'hFFFF);
    rd(4'd6, v);  chk("R8 mask upper bits ignored", v, 'h3FF);
    wr(4'd9, 'h3FF);
    rx_send('h11, 'hF);
    ris_exp = 'h03D;
    for (int b = 0; b < 10; b++) begin
      wr(4'd6, 1 << b);
      chk("R10 irq per mask bit", int'(irq), (ris_exp >> b) & 1);
      rd(4'd8, v); chk("R10 masked status", v, ris_exp & (1 << b));
    end
    rd(4'd0, v);  chk("R2 full tag", v, 'hF11);

    // modem change and partial clear
    wr(4'd9, 'h3FF);
    @(negedge clk); modem_cts = 1'b1;
    rd(4'd2, v);  chk("R3 cts flag", v, 'h91);
    @(negedge clk); modem_dcd = 1'b1;
    rd(4'd2, v);  chk("R3 dcd flag", v, 'h95);
    rd(4'd7, v);  chk("R9 modem change events", v, 'h180);
    wr(4'd9, 'h080);
    rd(4'd7, v);  chk("R9 partial clear", v, 'h100);
    wr(4'd6, 'h080);
    chk("R10 irq off after clear", int'(irq), 0);

    finish_run();
  end
endmodule